// File: doc/BRIEF.md
# Fully Associative Translation Cache with True LRU Replacement

This block holds a small set of virtual-page to physical-frame mappings and translates an incoming virtual address in the same cycle it is presented. The address is split into a page number (upper bits) and a byte offset (lower `OFF_W` bits). With the defaults, pages are 1024 bytes, so the page is the address divided by 1024 and the offset is the address modulo 1024. On a match the block returns the physical address, built as frame times the page size plus the offset. On a miss the requester resolves the mapping elsewhere and installs it through the fill port.

Replacement is exact least-recently-used. Every entry carries a recency rank, and both lookup hits and fills move an entry to the most-recent position. A fill first reuses the entry that already holds the same page. Failing that, it takes the lowest-numbered empty slot, and only evicts the least recently used entry when every slot is occupied. A flush input empties the whole cache in one cycle. Two counters record lookup hits and misses so that the hit ratio can be measured.

Top module: `tlb_lru`

## Requirements
- R1: A lookup (`lk_valid`=1) raises `lk_hit` in the same cycle when a valid entry holds the page number `lk_addr[VA_W-1:OFF_W]`. When `lk_valid` is 0, `lk_hit` is 0.
- R2: On a hit, `lk_paddr` = `{frame, lk_addr[OFF_W-1:0]}`, which is frame*1024 + offset with the defaults. On a miss, or when no lookup is made, `lk_paddr` is 0.
- R3: After reset every entry is invalid, every lookup misses, and both counters read 0.
- R4: While empty slots exist, a fill of a new page goes into the lowest-numbered empty slot and evicts nothing. `ENTRIES` distinct fills after reset or flush all stay resident.
- R5: With all slots valid, a fill of a new page evicts the least recently used entry, and a lookup hit makes its entry the most recent. With 4 entries, the accesses 0,1,0,2,3,4 (miss followed by fill) evict page 1 and keep pages 0,2,3,4.
- R6: A fill for a page that is already resident overwrites its frame in place, creates no second copy, and makes that entry the most recent.
- R7: `flush` invalidates every entry and restores the initial recency order in one cycle. From the next cycle on, lookups miss.
- R8: When `flush` and `fill_valid` are asserted in the same cycle, the flush wins and the fill is discarded.
- R9: A lookup in the same cycle as a fill reports the state from before that fill. The lookup hit's recency update takes effect before the fill chooses its victim.
- R10: Each cycle with `lk_valid`=1 adds one to exactly one of `hit_count` (on a hit) or `miss_count` (on a miss). The new value is visible after that clock edge. Cycles with `lk_valid`=0 add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_paddr | output | PFN_W+OFF_W | Translated physical address (0 on miss) |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_page | input | VA_W-OFF_W | Page number to install |
| fill_frame | input | PFN_W | Frame number for that page |
| flush | input | 1 | Invalidate all entries |
| hit_count | output | CNT_W | Number of lookup hits |
| miss_count | output | CNT_W | Number of lookup misses |

## Verification
The interesting overlap is a lookup and a fill landing on the same clock edge, since both want to rewrite the recency ranks. The bench fills all four slots in order, then, in a single cycle, looks up the oldest page while filling a new one. It judges the result by which page disappeared: the second-oldest must be evicted and the looked-up page must survive. A second overlap looks up the very page being filled and expects a miss in that cycle and a hit in the next. The overlap of flush with fill is provoked the same way, and the fill must have no effect.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Where a fill lands
  typedef enum logic [1:0] {
    SRC_RESIDENT = 2'd0,  // page already present: overwrite in place
    SRC_FREE     = 2'd1,  // lowest empty slot
    SRC_EVICT    = 2'd2   // least recently used slot
  } fill_src_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags_i,
  input  logic [VPN_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_o;

endmodule

// File: rtl/tlb_lru_order.sv
module tlb_lru_order
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic               fill_en,
  input  logic               fill_res_hit,
  input  logic [IDX_W-1:0]   fill_res_idx,
  output logic [IDX_W-1:0]   fill_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // rank 0 = most recent, ENTRIES-1 = least recent
  logic [IDX_W-1:0] rank_q [ENTRIES];
  logic [IDX_W-1:0] rank_a [ENTRIES];
  logic [IDX_W-1:0] rank_b [ENTRIES];

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] lru_idx;
  fill_src_e        src;

  // stage A: lookup-hit refresh
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      rank_a[i] = rank_q[i];
      if (touch_en) begin
        if (IDX_W'(i) == touch_idx)               rank_a[i] = '0;
        else if (rank_q[i] < rank_q[touch_idx])   rank_a[i] = rank_q[i] + 1'b1;
      end
    end
  end

  // victim choice, seen after stage A
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    lru_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rank_a[i] == OLDEST) lru_idx = IDX_W'(i);
    end
    if (fill_res_hit)    src = SRC_RESIDENT;
    else if (free_found) src = SRC_FREE;
    else                 src = SRC_EVICT;
    case (src)
      SRC_RESIDENT: fill_idx = fill_res_idx;
      SRC_FREE:     fill_idx = free_idx;
      default:      fill_idx = lru_idx;
    endcase
  end

  // stage B: fill refresh on top of stage A
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      rank_b[i] = rank_a[i];
      if (IDX_W'(i) == fill_idx)               rank_b[i] = '0;
      else if (rank_a[i] < rank_a[fill_idx])   rank_b[i] = rank_a[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (fill_en) begin
      rank_q <= rank_b;
    end else if (touch_en) begin
      rank_q <= rank_a;
    end
  end

  // ranks must stay a permutation of 0..ENTRIES-1
  logic [ENTRIES-1:0] occ [ENTRIES];
  always_comb begin
    for (int v = 0; v < ENTRIES; v++)
      for (int i = 0; i < ENTRIES; i++)
        occ[v][i] = (rank_q[i] == IDX_W'(v));
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int v = 0; v < ENTRIES; v++) begin
        a_r5_rank_perm: assert ($onehot(occ[v]))
          else $error("recency ranks are not a permutation");
      end
    end
  end

  a_r5_hit_mru: assert property (@(posedge clk) disable iff (rst)
    (touch_en && !fill_en && !flush) |=> rank_q[$past(touch_idx)] == '0);

  a_r6_fill_mru: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> rank_q[$past(fill_idx)] == '0);

endmodule

// File: rtl/tlb_stats.sv
module tlb_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic             lk_hit,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else if (lk_valid) begin
      if (lk_hit) hit_count  <= hit_count + 1'b1;
      else        miss_count <= miss_count + 1'b1;
    end
  end

  a_r10_one_count: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> CNT_W'(hit_count + miss_count) ==
                 CNT_W'($past(hit_count) + $past(miss_count) + 1'b1));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> $stable(hit_count) && $stable(miss_count));

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 4,
  parameter int VA_W    = 18,
  parameter int OFF_W   = 10,
  parameter int PFN_W   = 8,
  parameter int CNT_W   = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_addr,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_page,
  input  logic [PFN_W-1:0] fill_frame,
  input  logic             flush,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] frame_q;

  logic [VPN_W-1:0]   lk_page;
  logic [ENTRIES-1:0] lk_vec, fl_vec;
  logic               lk_match, fl_match;
  logic [IDX_W-1:0]   lk_idx, fl_idx, fill_idx;
  logic               fill_en;

  assign lk_page = lk_addr[VA_W-1:OFF_W];
  assign fill_en = fill_valid && !flush;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
    .valid_i(valid_q), .tags_i(tag_q), .key_i(lk_page),
    .match_o(lk_vec), .hit_o(lk_match), .idx_o(lk_idx));

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fl_match (
    .valid_i(valid_q), .tags_i(tag_q), .key_i(fill_page),
    .match_o(fl_vec), .hit_o(fl_match), .idx_o(fl_idx));

  tlb_lru_order #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_order (
    .clk(clk), .rst(rst), .flush(flush), .valid_i(valid_q),
    .touch_en(lk_hit), .touch_idx(lk_idx),
    .fill_en(fill_en), .fill_res_hit(fl_match), .fill_res_idx(fl_idx),
    .fill_idx(fill_idx));

  tlb_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .hit_count(hit_count), .miss_count(miss_count));

  assign lk_hit   = lk_valid && lk_match;
  assign lk_paddr = lk_hit ? {frame_q[lk_idx], lk_addr[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  // payload: no reset, written only by fills
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]   <= fill_page;
      frame_q[fill_idx] <= fill_frame;
    end
  end

  a_r6_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec) && $onehot0(fl_vec));

  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> valid_q == '0);

  a_r3_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (valid_q == '0 && hit_count == '0 && miss_count == '0));

  a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_hit && lk_paddr == '0);

endmodule

// File: tb/tlb_lru_test.sv
module tlb_lru_test;

  localparam int VA_W  = 18;
  localparam int OFF_W = 10;
  localparam int PFN_W = 8;
  localparam int CNT_W = 16;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0;
  logic [VA_W-1:0]  lk_addr = '0;
  logic             lk_hit;
  logic [PA_W-1:0]  lk_paddr;
  logic             fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_page = '0;
  logic [PFN_W-1:0] fill_frame = '0;
  logic             flush = 1'b0;
  logic [CNT_W-1:0] hit_count, miss_count;

  int errors = 0;
  int checks = 0;
  int exp_hits = 0;
  int exp_misses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlb_lru uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_valid(fill_valid),
    .fill_page(fill_page), .fill_frame(fill_frame), .flush(flush),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic int fr(int page);
    return (page + 8'h40) & 8'hff;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic lookup(int page, int off, bit exp_hit, int exp_frame, string req);
    int exp_pa;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = VA_W'(page * 1024 + off);
    #1;
    exp_pa = exp_hit ? exp_frame * 1024 + off : 0;
    check(lk_hit == exp_hit, req, $sformatf("hit page %0d", page), int'(lk_hit), int'(exp_hit));
    check(int'(lk_paddr) == exp_pa, req, $sformatf("paddr page %0d", page), int'(lk_paddr), exp_pa);
    if (exp_hit) exp_hits++; else exp_misses++;
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic fill(int page, int frame);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_page  = VPN_W'(page);
    fill_frame = PFN_W'(frame);
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic access(int page, bit exp_hit, string req);
    lookup(page, 3, exp_hit, fr(page), req);
    if (!exp_hit) fill(page, fr(page));
  endtask

  task automatic check_counts(string req);
    check(int'(hit_count) == exp_hits, req, "hit_count", int'(hit_count), exp_hits);
    check(int'(miss_count) == exp_misses, req, "miss_count", int'(miss_count), exp_misses);
  endtask

  task automatic t_reset();
    check_counts("R3");
    lookup(0, 0, 1'b0, 0, "R3");
    lookup(5, 9, 1'b0, 0, "R3");
  endtask

  task automatic t_free_fill();
    for (int p = 5; p < 9; p++) fill(p, fr(p));
    for (int p = 5; p < 9; p++) lookup(p, 700, 1'b1, fr(p), "R4");
    lookup(9, 700, 1'b0, 0, "R2");
    // R1: matching address without lk_valid gives no hit
    @(negedge clk);
    lk_addr = VA_W'(5 * 1024);
    #1;
    check(lk_hit == 1'b0, "R1", "hit with lk_valid low", int'(lk_hit), 0);
    check(lk_paddr == '0, "R2", "paddr with lk_valid low", int'(lk_paddr), 0);
  endtask

  task automatic t_flush();
    do_flush();
    lookup(5, 1, 1'b0, 0, "R7");
    lookup(8, 1, 1'b0, 0, "R7");
  endtask

  task automatic t_lru_sequence();
    access(0, 1'b0, "R5");
    access(1, 1'b0, "R5");
    access(0, 1'b1, "R5");
    access(2, 1'b0, "R5");
    access(3, 1'b0, "R5");
    access(4, 1'b0, "R5");
    lookup(1, 3, 1'b0, 0, "R5");
    for (int p = 2; p < 5; p++) lookup(p, 3, 1'b1, fr(p), "R5");
    lookup(0, 3, 1'b1, fr(0), "R5");
  endtask

  task automatic t_refill();
    do_flush();
    for (int p = 0; p < 4; p++) fill(p, fr(p));
    fill(0, 8'h99);
    fill(4, fr(4));
    lookup(0, 100, 1'b1, 8'h99, "R6");
    lookup(1, 100, 1'b0, 0, "R6");
    for (int p = 2; p < 5; p++) lookup(p, 100, 1'b1, fr(p), "R6");
  endtask

  task automatic t_collide();
    do_flush();
    for (int p = 0; p < 4; p++) fill(p, fr(p));
    // lookup oldest page while a new page is filled
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = VA_W'(0 * 1024 + 5);
    fill_valid = 1'b1; fill_page = VPN_W'(9); fill_frame = PFN_W'(fr(9));
    #1;
    check(lk_hit == 1'b1, "R9", "hit during fill", int'(lk_hit), 1);
    check(int'(lk_paddr) == fr(0) * 1024 + 5, "R9", "paddr during fill", int'(lk_paddr), fr(0) * 1024 + 5);
    exp_hits++;
    @(posedge clk); #1;
    lk_valid = 1'b0; fill_valid = 1'b0;
    // lookup of the page being filled sees the old state
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = VA_W'(10 * 1024 + 7);
    fill_valid = 1'b1; fill_page = VPN_W'(10); fill_frame = PFN_W'(fr(10));
    #1;
    check(lk_hit == 1'b0, "R9", "same-page hit during fill", int'(lk_hit), 0);
    exp_misses++;
    @(posedge clk); #1;
    lk_valid = 1'b0; fill_valid = 1'b0;
    lookup(10, 7, 1'b1, fr(10), "R9");
    lookup(1, 0, 1'b0, 0, "R9");
    lookup(2, 0, 1'b0, 0, "R9");
    lookup(0, 0, 1'b1, fr(0), "R9");
    lookup(9, 0, 1'b1, fr(9), "R9");
    lookup(3, 0, 1'b1, fr(3), "R9");
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_page = VPN_W'(7); fill_frame = PFN_W'(fr(7));
    @(posedge clk); #1;
    flush = 1'b0; fill_valid = 1'b0;
    lookup(7, 0, 1'b0, 0, "R8");
    lookup(0, 0, 1'b0, 0, "R8");
    for (int p = 20; p < 24; p++) fill(p, fr(p));
    for (int p = 20; p < 24; p++) lookup(p, 2, 1'b1, fr(p), "R7");
  endtask

  task automatic t_counters();
    repeat (3) @(negedge clk);
    check_counts("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_free_fill();
    t_flush();
    t_lru_sequence();
    t_refill();
    t_collide();
    t_flush_fill();
    t_counters();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule